// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Sequencer

This block is a master-side sequencer for a two-wire serial memory. It sits on top of a bit-level bus engine. Once the host's write has been closed with a stop condition, the host starts this block. The block then probes the memory again and again until the memory shows that its internal programming cycle is over. A fixed delay sized for the worst case (the cycle usually takes about 5 ms) is no longer needed.

Each probe is a start condition followed by the device address with the direction bit cleared. While the memory is programming, it does not acknowledge that byte. On a missing acknowledge the sequencer closes the transaction with a stop and tries again. The first acknowledged probe ends the loop, and the next step depends on the kind of operation that is queued:
- **Queued write:** the byte address is sent at once and the bus is left open for the data phase.
- **Queued read:** the bus is released with a stop.

An attempt limit bounds the loop and raises a sticky error flag if the memory never answers.

The engine command port uses a hold-until-done handshake. The sequencer holds `cmd_valid`, `cmd_op` and `cmd_byte` until the engine pulses `cmd_done`. With that same pulse, the engine reports in `cmd_ack` whether the byte just sent was acknowledged.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `ready` and `err` are 0 and `attempts` is 0.
- R2: A `go` sampled while idle starts polling with no inserted wait: in the next cycle `cmd_valid` is 1 with `cmd_op` = 2'b00 (start).
- R3: Every poll attempt is a start command (`cmd_op` 2'b00) followed by a byte command (`cmd_op` 2'b01) whose `cmd_byte` is `{dev_id, 1'b0}`.
- R4: When the engine reports no acknowledge for the probe byte, the next command is a stop (`cmd_op` 2'b10), followed by a fresh start. `attempts` rises by one per completed probe.
- R5: When the probe is acknowledged and the captured `next_wr` is 1, the next command is a byte command carrying the captured `next_addr`, and no stop is issued before handover.
- R6: When the probe is acknowledged and the captured `next_wr` is 0, the next command is a stop, after which control is handed over.
- R7: If `max_polls` probes in a row go unacknowledged (a value of 0 counts as 1), a stop is issued and `err` is set without any `ready` pulse. `err` stays 1 while idle until the next accepted `go` clears it.
- R8: Once presented, a command (`cmd_valid`, `cmd_op`, `cmd_byte`) is held unchanged until the cycle in which `cmd_done` is 1.
- R9: `go` is ignored while `busy` is 1; the sequence uses the `next_wr`, `next_addr`, `dev_id` and `max_polls` values captured with the accepted `go`.
- R10: On a successful handover `ready` is 1 for exactly one cycle, in the same cycle in which `busy` has returned to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start polling (write stop already issued) |
| next_wr | input | 1 | Queued operation is a write (1) or read (0) |
| next_addr | input | 8 | Byte address for the queued operation |
| dev_id | input | 7 | Device address of the memory |
| max_polls | input | CNT_W | Attempt limit (0 treated as 1) |
| cmd_valid | output | 1 | Command presented to the engine |
| cmd_op | output | 2 | 00 start, 01 send byte, 10 stop |
| cmd_byte | output | 8 | Byte for a send-byte command |
| cmd_done | input | 1 | Engine finished the presented command |
| cmd_ack | input | 1 | Acknowledge sampled for the byte just sent |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | One-cycle handover pulse |
| err | output | 1 | Attempt limit exhausted (sticky) |
| attempts | output | CNT_W | Probes completed in the current sequence |

## Verification
A wrong internal state shows up on the command port within one engine round trip:
- **Retry or exit path:** a mistaken choice appears as the wrong `cmd_op` in the command right after the probe's `cmd_done`. An example is a stop after an acknowledged probe when a write is queued.
- **Attempt counter:** a counter that is off by one ends the loop one probe early or late, so the count of start commands and the value of `attempts` both differ.
- **Captured inputs:** a stale or recaptured input shows as a wrong `cmd_byte`.
- **Handshake:** a broken hold changes the command before the `cmd_done` that consumes it.

// File: rtl/ackpoll_seq.sv
module ackpoll_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             next_wr,
  input  logic [7:0]       next_addr,
  input  logic [6:0]       dev_id,
  input  logic [CNT_W-1:0] max_polls,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             cmd_done,
  input  logic             cmd_ack,
  output logic             busy,
  output logic             ready,
  output logic             err,
  output logic [CNT_W-1:0] attempts
);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_START = 3'd1;
  localparam logic [2:0] S_ADDR  = 3'd2;
  localparam logic [2:0] S_RSTOP = 3'd3;
  localparam logic [2:0] S_BADDR = 3'd4;
  localparam logic [2:0] S_FSTOP = 3'd5;
  localparam logic [2:0] S_TSTOP = 3'd6;

  localparam logic [1:0] OP_START = 2'b00;
  localparam logic [1:0] OP_BYTE  = 2'b01;
  localparam logic [1:0] OP_STOP  = 2'b10;

  logic [2:0]       state;
  logic             wr_q;
  logic [7:0]       addr_q;
  logic [6:0]       dev_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nx;

  assign cnt_nx    = {1'b0, cnt_q} + 1'b1;
  assign busy      = (state != S_IDLE);
  assign cmd_valid = busy;
  assign attempts  = cnt_q;

  always_comb begin
    cmd_op   = OP_START;
    cmd_byte = 8'h00;
    case (state)
      S_ADDR:  begin cmd_op = OP_BYTE; cmd_byte = {dev_q, 1'b0}; end
      S_BADDR: begin cmd_op = OP_BYTE; cmd_byte = addr_q;        end
      S_RSTOP, S_FSTOP, S_TSTOP: cmd_op = OP_STOP;
      default: cmd_op = OP_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      wr_q   <= 1'b0;
      addr_q <= 8'h00;
      dev_q  <= 7'h00;
      lim_q  <= '0;
      cnt_q  <= '0;
      ready  <= 1'b0;
      err    <= 1'b0;
    end else begin
      ready <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          wr_q   <= next_wr;
          addr_q <= next_addr;
          dev_q  <= dev_id;
          lim_q  <= (max_polls == '0) ? CNT_W'(1) : max_polls;
          cnt_q  <= '0;
          err    <= 1'b0;
          state  <= S_START;
        end
        S_START: if (cmd_done) state <= S_ADDR;
        S_ADDR: if (cmd_done) begin
          cnt_q <= cnt_nx[CNT_W-1:0];
          if (cmd_ack)                      state <= wr_q ? S_BADDR : S_FSTOP;
          else if (cnt_nx >= {1'b0, lim_q}) state <= S_TSTOP;
          else                              state <= S_RSTOP;
        end
        S_RSTOP: if (cmd_done) state <= S_START;
        S_BADDR, S_FSTOP: if (cmd_done) begin
          state <= S_IDLE;
          ready <= 1'b1;
        end
        S_TSTOP: if (cmd_done) begin
          state <= S_IDLE;
          err   <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       cmd_done,
  input logic       cmd_ack,
  input logic       busy,
  input logic       ready,
  input logic       err,
  input logic [2:0] st
);

  assert_go_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> (cmd_valid && cmd_op == 2'b00));

  assert_probe_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && cmd_op == 2'b00) |=> (cmd_op == 2'b01 && cmd_byte[0] == 1'b0));

  assert_nack_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && cmd_done && !cmd_ack) |=> (cmd_valid && cmd_op == 2'b10));

  assert_write_no_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4) |-> (cmd_op == 2'b01));

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  assert_hold_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!busy && !err) ##1 !ready);

endmodule

bind ackpoll_seq ackpoll_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_byte(cmd_byte), .cmd_done(cmd_done), .cmd_ack(cmd_ack), .busy(busy),
  .ready(ready), .err(err), .st(state)
);

// File: tb/tb_ackpoll_seq.sv
module tb_ackpoll_seq;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic next_wr = 1'b0;
  logic [7:0] next_addr = 8'h00;
  logic [6:0] dev_id = 7'h00;
  logic [CNT_W-1:0] max_polls = '0;
  logic cmd_valid, busy, ready, err;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic cmd_done, cmd_ack;
  logic [CNT_W-1:0] attempts;

  int checks = 0, fails = 0, cycles = 0;
  int mem_busy = 0;
  int ready_cnt = 0;

  always #2.5 clk = ~clk;

  ackpoll_seq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .next_wr(next_wr), .next_addr(next_addr),
    .dev_id(dev_id), .max_polls(max_polls), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_done(cmd_done), .cmd_ack(cmd_ack), .busy(busy),
    .ready(ready), .err(err), .attempts(attempts)
  );

  // engine model: 3-cycle command latency, logs every completed command
  logic [1:0] op_log [0:63];
  logic [7:0] byte_log [0:63];
  int n_ops = 0, nacks = 0, dly = 0;
  logic after_start = 1'b0;

  always @(posedge clk) begin
    cmd_done <= 1'b0;
    if (!rst_n) begin
      cmd_ack <= 1'b0; dly <= 0; n_ops <= 0; nacks <= 0; after_start <= 1'b0;
    end else if (go && !busy) begin
      n_ops <= 0; nacks <= 0; dly <= 0;
    end else if (cmd_done) begin
      dly <= 0;
    end else if (cmd_valid) begin
      if (dly == 2) begin
        dly <= 0;
        cmd_done <= 1'b1;
        if (n_ops < 64) begin op_log[n_ops] <= cmd_op; byte_log[n_ops] <= cmd_byte; end
        n_ops <= n_ops + 1;
        after_start <= (cmd_op == 2'b00);
        if (cmd_op == 2'b01 && after_start) begin
          cmd_ack <= (nacks >= mem_busy);
          if (nacks < mem_busy) nacks <= nacks + 1;
        end else begin
          cmd_ack <= 1'b1;
        end
      end else dly <= dly + 1;
    end
  end

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && ready) ready_cnt <= ready_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic launch(input bit wr, input logic [7:0] a, input logic [6:0] d,
                        input int mp, input int mb);
    @(negedge clk);
    mem_busy = mb; next_wr = wr; next_addr = a; dev_id = d; max_polls = CNT_W'(mp);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(cmd_valid && cmd_op == 2'b00, "R2", "start right after go", int'(cmd_op), 0);
  endtask

  task automatic wait_idle(output int rdy_pulses);
    int r0 = ready_cnt;
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    chk(!busy, "R4", "sequence ends", int'(busy), 0);
    @(negedge clk);
    rdy_pulses = ready_cnt - r0;
  endtask

  task automatic expect_polls(input int tries, input logic [6:0] d, input string req);
    for (int i = 0; i < tries; i++) begin
      chk(op_log[3*i] == 2'b00, "R3", "probe start", int'(op_log[3*i]), 0);
      chk(op_log[3*i+1] == 2'b01 && byte_log[3*i+1] == {d, 1'b0}, "R3", "probe byte",
          int'(byte_log[3*i+1]), int'({d, 1'b0}));
      if (i < tries - 1)
        chk(op_log[3*i+2] == 2'b10, req, "stop after nack", int'(op_log[3*i+2]), 2);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !cmd_valid && !ready && !err && attempts == 0, "R1", "reset state",
        int'({busy, cmd_valid, ready, err}), 0);
  endtask

  task automatic t_write_immediate();
    int rp;
    launch(1'b1, 8'h5A, 7'h50, 4, 0);
    chk(ready == 1'b0, "R10", "no early ready", int'(ready), 0);
    wait_idle(rp);
    chk(n_ops == 3, "R5", "op count", n_ops, 3);
    expect_polls(1, 7'h50, "R4");
    chk(op_log[2] == 2'b01 && byte_log[2] == 8'h5A, "R5", "byte address follows",
        int'(byte_log[2]), 'h5A);
    chk(rp == 1, "R10", "single ready pulse", rp, 1);
    chk(attempts == 1, "R4", "attempts", int'(attempts), 1);
  endtask

  task automatic t_read_after_busy();
    int rp;
    launch(1'b0, 8'h11, 7'h2C, 10, 3);
    wait_idle(rp);
    chk(n_ops == 12, "R4", "op count with retries", n_ops, 12);
    expect_polls(4, 7'h2C, "R4");
    chk(op_log[11] == 2'b10, "R6", "stop before read handover", int'(op_log[11]), 2);
    chk(attempts == 4, "R4", "attempts", int'(attempts), 4);
    chk(rp == 1 && !err, "R6", "ready after read path", rp, 1);
  endtask

  task automatic t_timeout();
    int rp;
    launch(1'b1, 8'h77, 7'h41, 2, 5);
    wait_idle(rp);
    chk(n_ops == 6, "R7", "op count at limit", n_ops, 6);
    expect_polls(2, 7'h41, "R4");
    chk(op_log[5] == 2'b10, "R7", "final stop", int'(op_log[5]), 2);
    chk(err && rp == 0, "R7", "err set, no ready", int'({err, rp[0]}), 2);
    repeat (5) @(negedge clk);
    chk(err, "R7", "err sticky", int'(err), 1);
    launch(1'b0, 8'h00, 7'h41, 0, 3);
    chk(!err, "R7", "err cleared by go", int'(err), 0);
    wait_idle(rp);
    chk(n_ops == 3 && err, "R7", "limit 0 acts as 1", n_ops, 3);
  endtask

  task automatic t_go_while_busy();
    int rp;
    launch(1'b1, 8'hC3, 7'h1F, 8, 2);
    repeat (4) @(negedge clk);
    next_wr = 1'b0; next_addr = 8'h99; dev_id = 7'h7F; max_polls = 8'd1;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    wait_idle(rp);
    chk(n_ops == 9, "R9", "op count unchanged", n_ops, 9);
    expect_polls(3, 7'h1F, "R9");
    chk(byte_log[8] == 8'hC3, "R9", "captured address used", int'(byte_log[8]), 'hC3);
    chk(rp == 1, "R9", "one handover", rp, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_immediate();
    t_read_after_busy();
    t_timeout();
    t_go_while_busy();
    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    chk(1'b0, "R1", "watchdog expired", cycles, 0);
    finish_run();
  end
endmodule